// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block keeps a small table of words and finds entries by what they hold rather than by where they sit. Software or a neighbouring engine writes words into numbered slots, each with a valid flag. It loads a search key and a column-select pattern into two holding registers, then pulses a search strobe. Every slot is compared against the key in one parallel step. Only the bit columns that the select pattern enables take part in the comparison.

The outcome is a registered hit vector with one bit per slot. Any number of bits may be set, for example when several entries share the selected field. Two views of that vector are also provided: a flag that is high when at least one slot hit, and the index of the lowest-numbered slot that hit. The hit vector keeps its value until the next search strobe, so the table can be rewritten while earlier results are still read.

Top module: `maskedCam`

## Requirements
- R1: While reset is held, and after it is released, the hit vector, the hit flag and the hit index are all zero, and every slot is invalid, so a search with any key returns no hits.
- R2: After a search, hit bit i is 1 exactly when slot i is valid and, for every column j where the select bit is 1, bit j of the slot equals bit j of the key.
- R3: Columns whose select bit is 0 have no effect on the result. A slot that differs from the key only in deselected columns still hits.
- R4: With an all-zero select pattern, every valid slot hits and every invalid slot does not.
- R5: A slot written with its valid input at 0 is invalid and never hits, whatever data it holds.
- R6: The hit vector changes only at the clock edge on which the search strobe is high, and the new value can be read in the cycle that follows. Without a strobe it holds its value.
- R7: The hit flag is 1 exactly when at least one bit of the hit vector is 1.
- R8: The hit index equals the position of the lowest set bit of the hit vector, and it is 0 when no bit is set.
- R9: A search can set several hit bits at once, one for each matching valid slot.
- R10: When a slot write, a key load or a select load shares an edge with the search strobe, the search uses the table, key and select values held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write the slot chosen by wrIdx |
| wrIdx | input | IDXW | Slot number to write |
| wrData | input | W | Word to store |
| wrValid | input | 1 | Valid flag stored with the word |
| keyLoad | input | 1 | Load keyIn into the key register |
| keyIn | input | W | New search key |
| selLoad | input | 1 | Load selIn into the column-select register |
| selIn | input | W | New column-select pattern, 1 enables a column |
| searchGo | input | 1 | Start a search |
| hitVec | output | N | Registered hit bit per slot |
| hitAny | output | 1 | At least one slot hit |
| hitIdx | output | IDXW | Lowest-numbered hit slot, 0 if none |

## Verification
Slot writes and key and select loads take effect at the edge on which they are driven, and the hit vector, flag and index are all due in the cycle after the search strobe's edge. The bench drives every input just after a falling edge and samples all three outputs at the next falling edge, so each result is read one full cycle after its stimulus. Its reference model computes the expected hit vector from the model state as it stood before the strobe's edge, and then applies any writes or loads from that edge, which keeps searches that share an edge with updates honest. On cycles without a strobe the expected vector is carried over unchanged, so holding is checked every cycle.

// File: rtl/maskedCamPkg.sv
package maskedCamPkg;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic slotWe;
    logic keyWe;
    logic selWe;
    logic search;
  } camStrobe_t;

endpackage

// File: rtl/camCtrl.sv
module camCtrl
  import maskedCamPkg::*;
#(
  parameter int N    = 16,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic            keyLoad,
  input  logic            selLoad,
  input  logic            searchGo,
  output camStrobe_t      strobe,
  output logic [N-1:0]    slotSel
);

  always_comb begin
    strobe.slotWe = wrEn;
    strobe.keyWe  = keyLoad;
    strobe.selWe  = selLoad;
    strobe.search = searchGo;
  end

  // One-hot slot decode; an index past the table selects nothing
  for (genvar i = 0; i < N; i++) begin : gDecode
    assign slotSel[i] = wrEn && (wrIdx == IDXW'(i));
  end

endmodule

// File: rtl/camDatapath.sv
module camDatapath
  import maskedCamPkg::*;
#(
  parameter int N    = 16,
  parameter int W    = 8,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  camStrobe_t      strobe,
  input  logic [N-1:0]    slotSel,
  input  logic [W-1:0]    wrData,
  input  logic            wrValid,
  input  logic [W-1:0]    keyIn,
  input  logic [W-1:0]    selIn,
  output logic [N-1:0]    hitVec,
  output logic            hitAny,
  output logic [IDXW-1:0] hitIdx
);

  logic [W-1:0] keyReg;
  logic [W-1:0] selReg;
  logic [N-1:0] matchNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= '0;
      selReg <= '0;
    end else begin
      if (strobe.keyWe) keyReg <= keyIn;
      if (strobe.selWe) selReg <= selIn;
    end
  end

  // Per-slot storage and masked comparator
  for (genvar i = 0; i < N; i++) begin : gSlot
    logic [W-1:0] slotWord;
    logic         slotValid;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotWord  <= '0;
        slotValid <= 1'b0;
      end else if (slotSel[i] && strobe.slotWe) begin
        slotWord  <= wrData;
        slotValid <= wrValid;
      end
    end

    assign matchNow[i] = slotValid && (((slotWord ^ keyReg) & selReg) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              hitVec <= '0;
    else if (strobe.search) hitVec <= matchNow;
  end

  // Lowest-index priority encoder over the registered hit vector
  always_comb begin
    hitIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = IDXW'(i);
    end
  end

  assign hitAny = |hitVec;

endmodule

// File: rtl/maskedCam.sv
module maskedCam
  import maskedCamPkg::*;
#(
  parameter int N    = 16,
  parameter int W    = 8,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [W-1:0]    wrData,
  input  logic            wrValid,
  input  logic            keyLoad,
  input  logic [W-1:0]    keyIn,
  input  logic            selLoad,
  input  logic [W-1:0]    selIn,
  input  logic            searchGo,
  output logic [N-1:0]    hitVec,
  output logic            hitAny,
  output logic [IDXW-1:0] hitIdx
);

  camStrobe_t   strobe;
  logic [N-1:0] slotSel;

  camCtrl #(.N(N), .IDXW(IDXW)) u_ctrl (
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .keyLoad  (keyLoad),
    .selLoad  (selLoad),
    .searchGo (searchGo),
    .strobe   (strobe),
    .slotSel  (slotSel)
  );

  camDatapath #(.N(N), .W(W), .IDXW(IDXW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .slotSel (slotSel),
    .wrData  (wrData),
    .wrValid (wrValid),
    .keyIn   (keyIn),
    .selIn   (selIn),
    .hitVec  (hitVec),
    .hitAny  (hitAny),
    .hitIdx  (hitIdx)
  );

endmodule

// File: rtl/maskedCamChecker.sv
module maskedCamChecker #(
  parameter int N    = 16,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            searchGo,
  input logic [N-1:0]    hitVec,
  input logic            hitAny,
  input logic [IDXW-1:0] hitIdx
);

  logic [N-1:0] belowIdx;
  always_comb belowIdx = (N'(1) << hitIdx) - N'(1);

  // R1: reset clears the result
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (hitVec == '0));

  // R6: no strobe, no change
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !searchGo |=> $stable(hitVec));

  // R7: flag tracks the vector
  assert_any_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    hitAny == (hitVec != '0));

  // R8: index points at a set bit with none below it
  assert_lowest_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    hitAny |-> (hitVec[hitIdx] && ((hitVec & belowIdx) == '0)));

  // R8: index is zero without hits
  assert_idle_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hitAny |-> (hitIdx == '0));

endmodule

bind maskedCam maskedCamChecker #(.N(N), .IDXW(IDXW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .searchGo (searchGo),
  .hitVec   (hitVec),
  .hitAny   (hitAny),
  .hitIdx   (hitIdx)
);

// File: tb/maskedCam_tb.sv
module maskedCam_tb;
  localparam int N = 16;
  localparam int W = 8;
  localparam int IDXW = $clog2(N);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrValid = 0, keyLoad = 0, selLoad = 0, searchGo = 0;
  logic [IDXW-1:0] wrIdx = '0;
  logic [W-1:0] wrData = '0, keyIn = '0, selIn = '0;
  logic [N-1:0] hitVec;
  logic hitAny;
  logic [IDXW-1:0] hitIdx;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W-1:0] mWord [N];
  logic         mValid [N];
  logic [W-1:0] mKey, mSel;
  logic [N-1:0] expVec;

  always #(CLK_PERIOD/2) clk = ~clk;

  maskedCam #(.N(N), .W(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrValid(wrValid), .keyLoad(keyLoad), .keyIn(keyIn), .selLoad(selLoad),
    .selIn(selIn), .searchGo(searchGo), .hitVec(hitVec), .hitAny(hitAny),
    .hitIdx(hitIdx)
  );

  function automatic logic [N-1:0] modelSearch();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++)
      v[i] = mValid[i] && (((mWord[i] ^ mKey) & mSel) == '0);
    return v;
  endfunction

  function automatic logic [IDXW-1:0] lowestOf(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return IDXW'(i);
    return '0;
  endfunction

  task automatic check(string req);
    total++;
    if (hitVec !== expVec) begin
      bad++;
      $display("FAIL %s hitVec actual=%h expected=%h", req, hitVec, expVec);
    end
    total++;
    if (hitAny !== (expVec != '0)) begin
      bad++;
      $display("FAIL R7 (%s) hitAny actual=%b expected=%b", req, hitAny, expVec != '0);
    end
    total++;
    if (hitIdx !== lowestOf(expVec)) begin
      bad++;
      $display("FAIL R8 (%s) hitIdx actual=%0d expected=%0d", req, hitIdx, lowestOf(expVec));
    end
  endtask

  // One cycle: model the edge, let it pass, clear strobes
  task automatic cycle();
    if (searchGo) expVec = modelSearch();
    if (wrEn) begin
      mWord[wrIdx]  = wrData;
      mValid[wrIdx] = wrValid;
    end
    if (keyLoad) mKey = keyIn;
    if (selLoad) mSel = selIn;
    @(negedge clk);
    wrEn = 0; keyLoad = 0; selLoad = 0; searchGo = 0;
  endtask

  task automatic putSlot(int idx, logic [W-1:0] d, logic v);
    wrEn = 1; wrIdx = IDXW'(idx); wrData = d; wrValid = v;
    cycle();
  endtask

  task automatic setKeySel(logic [W-1:0] k, logic [W-1:0] s);
    keyLoad = 1; keyIn = k; selLoad = 1; selIn = s;
    cycle();
  endtask

  task automatic search(string req);
    searchGo = 1;
    cycle();
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] saved;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mWord[i] = '0; mValid[i] = 0; end
    mKey = '0; mSel = '0; expVec = '0;

    repeat (3) @(negedge clk);
    check("R1 during reset");
    rstN = 1;
    @(negedge clk);
    check("R1 after reset");
    search("R1 empty table search");

    // Duplicated field in the upper nibble across several slots
    putSlot(2, 8'hA3, 1);
    putSlot(5, 8'hA7, 1);
    putSlot(9, 8'hAC, 1);
    putSlot(11, 8'h53, 1);
    setKeySel(8'hA0, 8'hF0);
    search("R9 several slots share field");
    search("R2 repeat search");
    // Full-width compare
    setKeySel(8'hA7, 8'hFF);
    search("R2 exact word");
    // Differ only in deselected columns
    setKeySel(8'h03, 8'h0F);
    search("R3 deselected columns ignored");

    // Zero select pattern
    setKeySel(8'h5A, 8'h00);
    search("R4 zero select hits every valid slot");

    // Invalidate slot 2 while its data still matches
    putSlot(2, 8'hA3, 0);
    setKeySel(8'hA3, 8'hFF);
    search("R5 invalid slot never hits");

    // Hold: change key, write, no strobe
    saved = expVec;
    setKeySel(8'h00, 8'h00);
    putSlot(0, 8'h11, 1);
    check("R6 hold without strobe");

    // Same-edge write plus search uses old table
    setKeySel(8'h77, 8'hFF);
    wrEn = 1; wrIdx = IDXW'(4); wrData = 8'h77; wrValid = 1; searchGo = 1;
    cycle();
    check("R10 write with search uses old table");
    search("R10 write visible next search");
    keyLoad = 1; keyIn = 8'h11; searchGo = 1;
    cycle();
    check("R10 key load with search uses old key");
    setKeySel(8'hEE, 8'hFF);
    search("R8 no hit gives index zero");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom_range(0, 99);
      wrEn = (r < 35); wrIdx = IDXW'($urandom_range(0, N-1));
      wrData = W'($urandom_range(0, 3) == 0 ? 8'hA5 : $urandom);
      wrValid = ($urandom_range(0, 4) != 0);
      keyLoad = ($urandom_range(0, 3) == 0);
      keyIn = ($urandom_range(0, 1) == 0) ? 8'hA5 : W'($urandom);
      selLoad = ($urandom_range(0, 4) == 0);
      selIn = ($urandom_range(0, 5) == 0) ? 8'h00 : W'($urandom);
      searchGo = ($urandom_range(0, 2) == 0);
      cycle();
      check("R2 R6 R10 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule